// File: doc/BRIEF.md
# Output-Side Update Watchdog

This block sits at the driven end of a link that carries channel states. It keeps the channel outputs on only while updates keep arriving. Two kinds of update count as valid:
- a data transfer written by the host;
- the periodic refresh that the link sends on its own.

A valid update is one whose strobe arrives without the corruption flag. It loads its channel word and restarts a cycle counter. If the counter reaches the configured timeout with no valid update, every channel is forced off. The channels then stay off until the next valid update, which turns them back on with the newly delivered word.

Corrupted transfers are handled separately. A corrupted data transfer is dropped: the channels keep their previous state and the counter keeps running. A corrupted refresh transfer turns every channel off at once.

The controller has three states:
- `ST_OFF_TMO`: entered at reset and on timeout. All outputs are off.
- `ST_RUN`: the outputs follow the held word.
- `ST_OFF_LINK`: entered on a corrupted refresh. All outputs are off.

It has these transitions:
- ACCEPT: from any state to `ST_RUN`, on a valid update.
- EXPIRE: from `ST_RUN` to `ST_OFF_TMO`, on timeout.
- LINKERR: from `ST_RUN` to `ST_OFF_LINK`, on a corrupted refresh.
- HOLD: the state stays as it is for any other input.

Top module: `upd_watchdog`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in the tripped condition: `chan_out` is all zero and `wd_tripped` is 1.
- R2: A data transfer (`xfer_stb`=1, `xfer_is_refresh`=0, `xfer_corrupt`=0) is accepted at the clock edge where it is seen. From that edge on, `chan_out` equals `xfer_data` and `wd_tripped` is 0, from either off state as well as from run.
- R3: A refresh transfer (`xfer_stb`=1, `xfer_is_refresh`=1, `xfer_corrupt`=0) is a valid update. It loads its data and restarts the timeout exactly as a data transfer does.
- R4: Suppose no valid update occurs on the TIMEOUT_CYC clock edges that follow an accepting edge. Then, at the TIMEOUT_CYC-th of those edges, `chan_out` becomes all zero and `wd_tripped` becomes 1.
- R5: A valid update that arrives on that TIMEOUT_CYC-th edge prevents the trip and loads its data.
- R6: A corrupted data transfer (`xfer_corrupt`=1, `xfer_is_refresh`=0) leaves `chan_out` unchanged. It does not restart the timeout.
- R7: A corrupted refresh transfer (`xfer_corrupt`=1, `xfer_is_refresh`=1) seen while running turns every output off at that edge and sets `wd_tripped`.
- R8: In either off state, any cycle without a valid update leaves `chan_out` at zero and `wd_tripped` at 1. Corrupted strobes are included in this.
- R9: Whenever `wd_tripped` is 1, `chan_out` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_stb | input | 1 | One-cycle strobe: a transfer arrives this cycle |
| xfer_is_refresh | input | 1 | 1 = periodic refresh transfer, 0 = data transfer |
| xfer_corrupt | input | 1 | 1 = the transfer arrived corrupted |
| xfer_data | input | NUM_CH | Channel word carried by the transfer |
| chan_out | output | NUM_CH | Channel drive, 1 = on |
| wd_tripped | output | 1 | 1 while the outputs are forced off |

## Verification
A wrong internal state shows at the ports on the very next clock edge. A state that claims run while it should be off shows as non-zero `chan_out` together with `wd_tripped` low. A counter that was restarted by a corrupted transfer, or one that is off by one, moves the trip edge by at least one cycle. The timeout boundary is therefore probed on both sides: once with an update exactly on the expiring edge, and once with a run one edge longer. Each corrupted-strobe kind is applied both while running and while off, so that a mix-up between the two error rules changes the outputs within one cycle.

// File: rtl/upd_watchdog_pkg.sv
package upd_watchdog_pkg;
    typedef enum logic [1:0] {
        ST_OFF_TMO  = 2'd0,
        ST_RUN      = 2'd1,
        ST_OFF_LINK = 2'd2
    } wd_state_t;
endpackage

// File: rtl/upd_wd_timer.sv
module upd_wd_timer #(
    parameter int TIMEOUT_CYC = 32000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || !run)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    // expires on the edge that would take the count past its last value
    assign expired = run && !restart && (cnt_q == LAST);
endmodule

// File: rtl/upd_wd_hold.sv
module upd_wd_hold #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NUM_CH-1:0] din,
    output logic [NUM_CH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
    end
endmodule

// File: rtl/upd_watchdog.sv
module upd_watchdog
    import upd_watchdog_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int TIMEOUT_CYC = 32000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_stb,
    input  logic              xfer_is_refresh,
    input  logic              xfer_corrupt,
    input  logic [NUM_CH-1:0] xfer_data,
    output logic [NUM_CH-1:0] chan_out,
    output logic              wd_tripped
);
    wd_state_t         state_q, state_d;
    logic              accept;
    logic              link_err;
    logic              expired;
    logic [NUM_CH-1:0] held;

    assign accept   = xfer_stb && !xfer_corrupt;
    assign link_err = xfer_stb &&  xfer_corrupt && xfer_is_refresh;

    upd_wd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (state_q == ST_RUN),
        .expired (expired)
    );

    upd_wd_hold #(.NUM_CH(NUM_CH)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .din   (xfer_data),
        .q     (held)
    );

    // next-state logic: ACCEPT has priority, then LINKERR, then EXPIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF_TMO, ST_OFF_LINK: begin
                if (accept)
                    state_d = ST_RUN;
            end
            ST_RUN: begin
                if (accept)
                    state_d = ST_RUN;
                else if (link_err)
                    state_d = ST_OFF_LINK;
                else if (expired)
                    state_d = ST_OFF_TMO;
            end
            default: state_d = ST_OFF_TMO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF_TMO;
        else
            state_q <= state_d;
    end

    always_comb begin
        chan_out   = '0;
        wd_tripped = 1'b1;
        unique case (state_q)
            ST_RUN: begin
                chan_out   = held;
                wd_tripped = 1'b0;
            end
            ST_OFF_TMO, ST_OFF_LINK: begin
                chan_out   = '0;
                wd_tripped = 1'b1;
            end
            default: begin
                chan_out   = '0;
                wd_tripped = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/upd_watchdog_chk.sv
module upd_watchdog_chk #(
    parameter int NUM_CH      = 8,
    parameter int TIMEOUT_CYC = 32000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_stb,
    input logic              xfer_is_refresh,
    input logic              xfer_corrupt,
    input logic [NUM_CH-1:0] xfer_data,
    input logic [NUM_CH-1:0] chan_out,
    input logic              wd_tripped
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(TIMEOUT_CYC);

    logic          good;
    logic [CW-1:0] gap_q;

    assign good = xfer_stb && !xfer_corrupt;

    // edges since the last accepted update, saturating; starts full at reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap_q <= FULL;
        else if (good)
            gap_q <= '0;
        else if (gap_q != FULL)
            gap_q <= gap_q + 1'b1;
    end

    // R2
    accept_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good |=> (chan_out == $past(xfer_data)) && !wd_tripped);

    // R4
    timeout_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == FULL) |-> wd_tripped);

    // R6
    bad_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && xfer_corrupt && !xfer_is_refresh && !wd_tripped)
        |=> (chan_out == $past(chan_out)) || wd_tripped);

    // R7
    bad_refresh_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && xfer_corrupt && xfer_is_refresh && !wd_tripped)
        |=> wd_tripped && (chan_out == '0));

    // R8
    off_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_tripped && !good) |=> wd_tripped);

    // R9
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_tripped |-> (chan_out == '0));
endmodule

bind upd_watchdog upd_watchdog_chk #(
    .NUM_CH      (NUM_CH),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .xfer_stb        (xfer_stb),
    .xfer_is_refresh (xfer_is_refresh),
    .xfer_corrupt    (xfer_corrupt),
    .xfer_data       (xfer_data),
    .chan_out        (chan_out),
    .wd_tripped      (wd_tripped)
);

// File: tb/upd_watchdog_bench.sv
module upd_watchdog_bench;
    localparam int NCH = 8;
    localparam int TMO = 8;
    localparam int NV  = 23;

    // {stb, refresh, corrupt, data, expected chan_out, expected tripped}
    localparam logic [19:0] VEC [NV] = '{
        {1'b0,1'b0,1'b0,8'h00,8'h00,1'b1},  // 0  R8 idle while off
        {1'b1,1'b0,1'b1,8'hA5,8'h00,1'b1},  // 1  R8 corrupt data while off
        {1'b1,1'b1,1'b1,8'h3C,8'h00,1'b1},  // 2  R8 corrupt refresh while off
        {1'b1,1'b0,1'b0,8'hA5,8'hA5,1'b0},  // 3  R2 data accept
        {1'b0,1'b0,1'b0,8'h00,8'hA5,1'b0},  // 4
        {1'b0,1'b0,1'b0,8'h00,8'hA5,1'b0},  // 5
        {1'b0,1'b0,1'b0,8'h00,8'hA5,1'b0},  // 6
        {1'b0,1'b0,1'b0,8'h00,8'hA5,1'b0},  // 7
        {1'b0,1'b0,1'b0,8'h00,8'hA5,1'b0},  // 8
        {1'b0,1'b0,1'b0,8'h00,8'hA5,1'b0},  // 9
        {1'b0,1'b0,1'b0,8'h00,8'hA5,1'b0},  // 10
        {1'b1,1'b1,1'b0,8'h5A,8'h5A,1'b0},  // 11 R5 R3 refresh on the 8th edge
        {1'b1,1'b0,1'b1,8'hFF,8'h5A,1'b0},  // 12 R6 corrupt data holds
        {1'b0,1'b0,1'b0,8'h00,8'h5A,1'b0},  // 13
        {1'b0,1'b0,1'b0,8'h00,8'h5A,1'b0},  // 14
        {1'b0,1'b0,1'b0,8'h00,8'h5A,1'b0},  // 15
        {1'b0,1'b0,1'b0,8'h00,8'h5A,1'b0},  // 16
        {1'b0,1'b0,1'b0,8'h00,8'h5A,1'b0},  // 17
        {1'b0,1'b0,1'b0,8'h00,8'h5A,1'b0},  // 18
        {1'b0,1'b0,1'b0,8'h00,8'h00,1'b1},  // 19 R4 trip, R6 no restart
        {1'b1,1'b1,1'b0,8'h81,8'h81,1'b0},  // 20 R3 refresh recovers
        {1'b1,1'b1,1'b1,8'h7E,8'h00,1'b1},  // 21 R7 corrupt refresh off
        {1'b1,1'b0,1'b0,8'h0F,8'h0F,1'b0}   // 22 R2 data recovers
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           xfer_stb = 1'b0;
    logic           xfer_is_refresh = 1'b0;
    logic           xfer_corrupt = 1'b0;
    logic [NCH-1:0] xfer_data = '0;
    logic [NCH-1:0] chan_out;
    logic           wd_tripped;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    upd_watchdog #(.NUM_CH(NCH), .TIMEOUT_CYC(TMO)) u_upd_watchdog (
        .clk             (clk),
        .rst_n           (rst_n),
        .xfer_stb        (xfer_stb),
        .xfer_is_refresh (xfer_is_refresh),
        .xfer_corrupt    (xfer_corrupt),
        .xfer_data       (xfer_data),
        .chan_out        (chan_out),
        .wd_tripped      (wd_tripped)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state, during and after reset
        repeat (2) @(negedge clk);
        check("R1 out in reset", chan_out, 0);
        check("R1 tripped in reset", wd_tripped, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out after reset", chan_out, 0);
        check("R1 tripped after reset", wd_tripped, 1);

        for (int i = 0; i < NV; i++) begin
            {xfer_stb, xfer_is_refresh, xfer_corrupt, xfer_data} = VEC[i][19:9];
            @(negedge clk);
            check($sformatf("vec%0d out (R2-R9)", i), chan_out, VEC[i][8:1]);
            check($sformatf("vec%0d tripped (R2-R9)", i), wd_tripped, VEC[i][0]);
        end
        {xfer_stb, xfer_is_refresh, xfer_corrupt, xfer_data} = '0;

        // R9: running with 0F, then a full timeout with no update
        repeat (TMO - 1) @(negedge clk);
        check("R4 still on before limit", chan_out, 8'h0F);
        @(negedge clk);
        check("R4 tripped at limit", wd_tripped, 1);
        check("R9 out zero when tripped", chan_out, 0);

        // R1: reset asserted while running clears outputs
        xfer_stb = 1'b1; xfer_data = 8'hC3;
        @(negedge clk);
        xfer_stb = 1'b0;
        check("R2 load C3", chan_out, 8'hC3);
        rst_n = 1'b0;
        #1;
        check("R1 async reset out", chan_out, 0);
        check("R1 async reset tripped", wd_tripped, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 stays off after reset", wd_tripped, 1);

        finish_run();
    end
endmodule